// File: doc/BRIEF.md
# Dual-Parity Symbol Tracker

This block watches a stream of symbols drawn from a three-letter alphabet, one symbol per clock when a strobe marks it valid, and keeps two independent parity bits: one for how many `a` symbols have arrived since reset and one for how many `b` symbols have arrived. The third letter, `c`, leaves both parities as they are. The block is a Moore machine. Its single flag output is a function of the state register alone and is high only while the `a` count is even and the `b` count is odd.

The state register drives an output port so that surrounding logic or a bench can observe it directly. A sticky error flag records any valid cycle that carried the unused symbol code. That flag stays set until the next reset.

Top module: `parity_pair_fsm`

## Requirements
- R1: With `rst` high at a clock edge, the state goes to 2'b00 (even a, even b), `match` goes to 0 and `bad_sym` goes to 0.
- R2: Symbol code 2'b00 (`a`), when valid, toggles the a-parity: the state goes 00→11, 01→10, 10→01, 11→00.
- R3: Symbol code 2'b01 (`b`), when valid, toggles the b-parity: the state goes 00→01, 01→00, 10→11, 11→10.
- R4: Symbol code 2'b10 (`c`), when valid, leaves the state unchanged.
- R5: `match` is 1 exactly when the state is 2'b01 and is 0 in states 00, 10 and 11. It depends only on the state.
- R6: While `sym_vld` is low, the state holds for any `sym` value, and `bad_sym` is not set.
- R7: Symbol code 2'b11, when valid, holds the state and sets `bad_sym` at the next edge. Once set, `bad_sym` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_vld | input | 1 | Marks `sym` as valid in this cycle |
| sym | input | 2 | Symbol code: 00=a, 01=b, 10=c, 11=unused |
| match | output | 1 | High when the a-count is even and the b-count is odd |
| state | output | 2 | Current state: 00 EE, 01 EO, 10 OO, 11 OE |
| bad_sym | output | 1 | Sticky flag that records a valid unused code |

## Verification
The assertions check every cycle against the previous one:
- the state after each valid symbol, for every state and code;
- the state holding while the strobe is low;
- `match` agreeing with the state;
- the sticky behaviour of the error flag.

The bench's scenarios show what a single-cycle check cannot: the parity reached after long mixed sequences, invalid cycles placed between valid symbols, and a reset clearing a latched error.

// File: rtl/parity_pair_fsm.sv
module parity_pair_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_vld,
  input  logic [1:0] sym,
  output logic       match,
  output logic [1:0] state,
  output logic       bad_sym
);
  localparam logic [1:0] ST_EE = 2'b00;
  localparam logic [1:0] ST_EO = 2'b01;
  localparam logic [1:0] ST_OO = 2'b10;
  localparam logic [1:0] ST_OE = 2'b11;

  localparam logic [1:0] SYM_A = 2'b00;
  localparam logic [1:0] SYM_B = 2'b01;
  localparam logic [1:0] SYM_C = 2'b10;

  logic [1:0] st_q, st_d;
  logic       err_q;

  always_comb begin
    st_d = st_q;
    if (sym_vld) begin
      unique case (sym)
        SYM_A: st_d = ~st_q;
        SYM_B: st_d = {st_q[1], ~st_q[0]};
        SYM_C: st_d = st_q;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_EE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (sym_vld && sym == 2'b11) err_q <= 1'b1;
    end
  end

  assign state   = st_q;
  assign match   = (st_q == ST_EO);
  assign bad_sym = err_q;

  logic unused_ok;
  assign unused_ok = (ST_OO == ST_OE);
endmodule

module parity_pair_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       sym_vld,
  input logic [1:0] sym,
  input logic       match,
  input logic [1:0] state,
  input logic       bad_sym
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_STATE: assert property (@(posedge clk) seen && $past(rst) |-> state == 2'b00 && !bad_sym); // R1
  AST_A_TOGGLE: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && sym_vld && sym == 2'b00) |-> state == {~$past(state[1]), ~$past(state[0])}); // R2
  AST_B_TOGGLE: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && sym_vld && sym == 2'b01) |-> state[1] == $past(state[1]) && state[0] != $past(state[0])); // R3
  AST_C_HOLD: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && sym_vld && sym == 2'b10) |-> $stable(state)); // R4
  AST_MATCH_MAP: assert property (@(posedge clk) disable iff (rst) match == (state[0] && !state[1])); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && !sym_vld) |-> $stable(state) && $stable(bad_sym)); // R6
  AST_BAD_SET: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && sym_vld && sym == 2'b11) |-> bad_sym && $stable(state)); // R7
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst) seen && $past(!rst && bad_sym) |-> bad_sym); // R7
endmodule

bind parity_pair_fsm parity_pair_fsm_chk chk_i (.*);

// File: tb/parity_pair_fsm_tb_top.sv
module parity_pair_fsm_tb_top;
  logic clk = 1'b0;
  logic rst, sym_vld;
  logic [1:0] sym;
  logic match, bad_sym;
  logic [1:0] state;

  int n_cmp = 0, n_bad = 0;
  int a_cnt, b_cnt;
  bit m_err;

  always #5 clk = ~clk;

  parity_pair_fsm dut_i (.clk(clk), .rst(rst), .sym_vld(sym_vld), .sym(sym),
                         .match(match), .state(state), .bad_sym(bad_sym));

  function automatic logic [1:0] exp_state();
    bit oa = a_cnt % 2;
    bit ob = b_cnt % 2;
    if (!oa && !ob) return 2'b00;
    if (!oa &&  ob) return 2'b01;
    if ( oa &&  ob) return 2'b10;
    return 2'b11;
  endfunction

  task automatic compare(string tag);
    logic [1:0] es = exp_state();
    bit em = (a_cnt % 2 == 0) && (b_cnt % 2 == 1);
    n_cmp++;
    if (state !== es || match !== em || bad_sym !== m_err) begin
      n_bad++;
      $display("FAIL %s: state=%b match=%b bad=%b expected state=%b match=%b bad=%b",
               tag, state, match, bad_sym, es, em, m_err);
    end
  endtask

  task automatic step(bit v, logic [1:0] s, string tag);
    sym_vld = v; sym = s;
    @(posedge clk);
    if (v) begin
      case (s)
        2'b00: a_cnt++;
        2'b01: b_cnt++;
        2'b11: m_err = 1;
        default: ;
      endcase
    end
    #2 compare(tag);
  endtask

  task automatic do_reset();
    rst = 1; sym_vld = 0; sym = 2'b00;
    @(posedge clk); @(posedge clk);
    a_cnt = 0; b_cnt = 0; m_err = 0;
    #2 compare("R1 reset");
    rst = 0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    step(1, 2'b01, "R3 b 00->01 R5");
    step(1, 2'b00, "R2 a 01->10");
    step(1, 2'b01, "R3 b 10->11");
    step(1, 2'b00, "R2 a 11->00");
    step(1, 2'b00, "R2 a 00->11");
    step(1, 2'b01, "R3 b 11->10");
    step(1, 2'b00, "R2 a 10->01");
    step(1, 2'b01, "R3 b 01->00");
    step(1, 2'b01, "R3 b 00->01");
    step(1, 2'b10, "R4 c hold");
    for (int i = 0; i < 4; i++) step(0, 2'(i), "R6 idle hold");
    step(1, 2'b10, "R4 c hold 2");
    for (int i = 0; i < 300; i++) begin
      int r = (i * 7 + i / 5) % 9;
      bit v = (r != 4);
      logic [1:0] s = (r < 3) ? 2'b00 : (r < 6) ? 2'b01 : 2'b10;
      step(v, s, "R5 mixed");
    end
    step(1, 2'b11, "R7 bad code");
    step(1, 2'b00, "R7 sticky a");
    step(0, 2'b11, "R7 sticky idle");
    step(1, 2'b01, "R7 sticky b");
    do_reset();
    step(0, 2'b11, "R6 idle bad ignored");
    step(1, 2'b01, "R5 match after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule